// File: doc/BRIEF.md
# DDR SDRAM Command Bus Monitor

This block listens passively to the command pins of a DDR SDRAM interface. It samples them on every rising clock edge and names the command on the bus. For each of four banks it tracks whether a row is open and how long that bank must stay closed before it may be activated again. It drives nothing back onto the bus.

It raises a flag when the controller breaks one of these rules:
- a bank is activated too soon after an explicit precharge;
- a bank is activated too soon after a read or write that carries auto-precharge;
- a bank that is already open is activated;
- a closed bank is read or written;
- a mode register is programmed while a bank is open, or before the precharge recovery time has run out.

The error flag is sticky, and a cause code reports the first violation after reset. Burst length, precharge recovery (tRP) and write recovery (tWR) are parameters, so the reopen windows follow the memory's configuration.

A system instantiates the monitor next to a memory controller in simulation or on silicon debug paths. It watches the decoded command code and the bank state vector, and checks the error flag at the end of a run.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: Each sampled cycle is decoded into `cmd_code`, which is visible after the same rising edge that sampled it. With `chip_sel_n` low, {row,col,wr strobes} decode as: 000 mode register set (2), 001 refresh (3), 011 activate (4), 101 read (5/6), 100 write (7/8), 010 precharge (9/10), 110 burst stop (11), 111 no operation (0).
- R2: With `chip_sel_n` high the code is deselect (1), whatever the three strobes are.
- R3: When `clk_en` was low in the previous sampled cycle, the code is idle (12) and the command has no effect on bank state or errors.
- R4: Address bit `AP_BIT` (bit 10 by default) selects the variant. For reads it picks read with auto-precharge (6) over read (5). For writes it picks write with auto-precharge (8) over write (7). For precharge it picks precharge-all (10) over single-bank precharge (9).
- R5: An activate sets `bank_open[b]`, where b is `bank_sel`.
- R6: A single-bank precharge clears only `bank_open[bank_sel]`. A precharge-all clears every bit and ignores `bank_sel`.
- R7: An activate to an open bank raises cause 1.
- R8: After a precharge of bank b in cycle p, an activate of b before cycle p+tRP raises cause 2. An activate in cycle p+tRP is legal.
- R9: A read with auto-precharge to open bank b in cycle n closes b. An activate of b before n+BL/2+tRP raises cause 2.
- R10: A write with auto-precharge to open bank b in cycle n closes b. An activate of b before n+BL/2+1+tWR+tRP raises cause 2.
- R11: Any read or write, with or without auto-precharge, to a closed bank raises cause 3 and leaves `bank_open` unchanged.
- R12: A mode register set raises cause 4 if any bank is open. Otherwise it raises cause 5 while any bank's reopen window is still running. On every mode register set, `mode_ext` equals `bank_sel[0]` (1 means the extended register) and `mode_operand` latches {`bank_sel`, `bus_addr`}. Outside a mode register set, `mode_ext` is 0.
- R13: Reset gives code 12, all banks closed, flag 0, cause 0, `mode_ext` 0 and operand 0. Once set, `err_flag` stays high, and `err_cause` keeps the first cause until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Clock-enable pin of the bus |
| chip_sel_n | input | 1 | Active-low chip select |
| row_strobe_n | input | 1 | Active-low row strobe |
| col_strobe_n | input | 1 | Active-low column strobe |
| wr_strobe_n | input | 1 | Active-low write strobe |
| bank_sel | input | BA_W | Bank address |
| bus_addr | input | ADDR_W | Address bus, bit AP_BIT is the auto-precharge select |
| cmd_code | output | 4 | Decoded command code |
| mode_ext | output | 1 | High for an extended mode register set |
| mode_operand | output | ADDR_W+BA_W | Operand of the last mode register set |
| bank_open | output | 2**BA_W | One bit per bank, high when a row is open |
| err_flag | output | 1 | Sticky violation flag |
| err_cause | output | 3 | Cause of the first violation |

## Verification
Every output is registered. The effect of a command sampled at rising edge n is therefore due just after edge n, which is one edge after the bench applies it. The driver applies each command on a falling edge and pushes the expected outputs into a queue. The monitor pops one entry 2 ns after each following rising edge, so no compare lands on an edge. Reopen windows are tested on both sides of the boundary, at one cycle short and at exactly the permitted cycle, with padding no-operation cycles counted in the bench's cycle index.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_DESEL = 4'd1,
    CMD_MRS   = 4'd2,
    CMD_REF   = 4'd3,
    CMD_ACT   = 4'd4,
    CMD_RD    = 4'd5,
    CMD_RDA   = 4'd6,
    CMD_WR    = 4'd7,
    CMD_WRA   = 4'd8,
    CMD_PRE   = 4'd9,
    CMD_PREA  = 4'd10,
    CMD_BST   = 4'd11,
    CMD_IDLE  = 4'd12
  } bus_cmd_e;

  typedef enum logic [2:0] {
    FLT_NONE       = 3'd0,
    FLT_ACT_OPEN   = 3'd1,
    FLT_ACT_EARLY  = 3'd2,
    FLT_ACC_CLOSED = 3'd3,
    FLT_MRS_OPEN   = 3'd4,
    FLT_MRS_EARLY  = 3'd5
  } fault_e;

  // cycles from a read with auto-precharge to the first legal activate
  function automatic int unsigned rd_reopen_gap(int unsigned burst, int unsigned t_rp);
    return burst / 2 + t_rp;
  endfunction

  // cycles from a write with auto-precharge to the first legal activate
  function automatic int unsigned wr_reopen_gap(int unsigned burst, int unsigned t_wr,
                                                int unsigned t_rp);
    return burst / 2 + 1 + t_wr + t_rp;
  endfunction

  // bits needed to hold a countdown that starts at gap-1
  function automatic int unsigned lock_width(int unsigned gap);
    return (gap < 3) ? 1 : $clog2(gap);
  endfunction

  function automatic logic is_access(bus_cmd_e c);
    return (c == CMD_RD) || (c == CMD_RDA) || (c == CMD_WR) || (c == CMD_WRA);
  endfunction

endpackage

// File: rtl/ddr_cmd_classify.sv
module ddr_cmd_classify
  import ddr_mon_pkg::*;
(
  input  logic     en_prev,
  input  logic     chip_sel_n,
  input  logic     row_strobe_n,
  input  logic     col_strobe_n,
  input  logic     wr_strobe_n,
  input  logic     ap_bit,
  output bus_cmd_e cmd
);

  always_comb begin
    if (!en_prev) begin
      cmd = CMD_IDLE;
    end else if (chip_sel_n) begin
      cmd = CMD_DESEL;
    end else begin
      case ({row_strobe_n, col_strobe_n, wr_strobe_n})
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = CMD_REF;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = ap_bit ? CMD_RDA : CMD_RD;
        3'b100:  cmd = ap_bit ? CMD_WRA : CMD_WR;
        3'b010:  cmd = ap_bit ? CMD_PREA : CMD_PRE;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_req,
  input  logic             close_req,
  input  logic [CNT_W-1:0] lock_load,
  output logic             is_open,
  output logic             is_ready
);

  logic [CNT_W-1:0] lock_q;
  logic [CNT_W-1:0] lock_dec;
  logic [CNT_W-1:0] lock_nxt;

  assign lock_dec = (lock_q == '0) ? '0 : lock_q - 1'b1;
  // a new window never shortens one that is still running
  assign lock_nxt = (close_req && (lock_load > lock_dec)) ? lock_load : lock_dec;
  assign is_ready = (lock_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      lock_q  <= '0;
    end else begin
      if (open_req)       is_open <= 1'b1;
      else if (close_req) is_open <= 1'b0;
      lock_q <= lock_nxt;
    end
  end

endmodule

// File: rtl/ddr_bank_array.sv
module ddr_bank_array
  import ddr_mon_pkg::*;
#(
  parameter int unsigned BA_W      = 2,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_WR      = 2,
  localparam int unsigned NUM_BANKS = 1 << BA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  bus_cmd_e             cmd,
  input  logic [BA_W-1:0]      bank_sel,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [NUM_BANKS-1:0] bank_ready
);

  localparam int unsigned RD_GAP = rd_reopen_gap(BURST_LEN, T_RP);
  localparam int unsigned WR_GAP = wr_reopen_gap(BURST_LEN, T_WR, T_RP);
  localparam int unsigned CNT_W  = lock_width(WR_GAP);
  localparam logic [CNT_W-1:0] PRE_LOAD = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_GAP - 1);
  localparam logic [CNT_W-1:0] WR_LOAD  = CNT_W'(WR_GAP - 1);

  logic [CNT_W-1:0] load_sel;

  always_comb begin
    case (cmd)
      CMD_RDA: load_sel = RD_LOAD;
      CMD_WRA: load_sel = WR_LOAD;
      default: load_sel = PRE_LOAD;
    endcase
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit, auto_close, pre_close, open_req;
    assign hit        = (bank_sel == BA_W'(b));
    assign open_req   = hit && (cmd == CMD_ACT);
    assign auto_close = hit && bank_open[b] && ((cmd == CMD_RDA) || (cmd == CMD_WRA));
    assign pre_close  = (hit && (cmd == CMD_PRE)) || (cmd == CMD_PREA);

    ddr_bank_slot #(.CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_req  (open_req),
      .close_req (auto_close || pre_close),
      .lock_load (load_sel),
      .is_open   (bank_open[b]),
      .is_ready  (bank_ready[b])
    );
  end

endmodule

// File: rtl/ddr_rule_check.sv
module ddr_rule_check
  import ddr_mon_pkg::*;
#(
  parameter int unsigned BA_W = 2,
  localparam int unsigned NUM_BANKS = 1 << BA_W
) (
  input  bus_cmd_e             cmd,
  input  logic [BA_W-1:0]      bank_sel,
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic [NUM_BANKS-1:0] bank_ready,
  output logic                 viol,
  output fault_e               cause
);

  always_comb begin
    cause = FLT_NONE;
    if (cmd == CMD_ACT) begin
      if (bank_open[bank_sel])        cause = FLT_ACT_OPEN;
      else if (!bank_ready[bank_sel]) cause = FLT_ACT_EARLY;
    end else if (is_access(cmd)) begin
      if (!bank_open[bank_sel])       cause = FLT_ACC_CLOSED;
    end else if (cmd == CMD_MRS) begin
      if (|bank_open)                 cause = FLT_MRS_OPEN;
      else if (!(&bank_ready))        cause = FLT_MRS_EARLY;
    end
    viol = (cause != FLT_NONE);
  end

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned AP_BIT    = 10,
  parameter int unsigned BA_W      = 2,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_WR      = 2,
  localparam int unsigned NUM_BANKS = 1 << BA_W,
  localparam int unsigned OP_W      = ADDR_W + BA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_en,
  input  logic                 chip_sel_n,
  input  logic                 row_strobe_n,
  input  logic                 col_strobe_n,
  input  logic                 wr_strobe_n,
  input  logic [BA_W-1:0]      bank_sel,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic [3:0]           cmd_code,
  output logic                 mode_ext,
  output logic [OP_W-1:0]      mode_operand,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic                 err_flag,
  output logic [2:0]           err_cause
);

  logic                 en_prev;
  bus_cmd_e             cmd_now;
  logic                 viol_now;
  fault_e               cause_now;
  logic [NUM_BANKS-1:0] bank_ready;

  ddr_cmd_classify u_classify (
    .en_prev      (en_prev),
    .chip_sel_n   (chip_sel_n),
    .row_strobe_n (row_strobe_n),
    .col_strobe_n (col_strobe_n),
    .wr_strobe_n  (wr_strobe_n),
    .ap_bit       (bus_addr[AP_BIT]),
    .cmd          (cmd_now)
  );

  ddr_bank_array #(
    .BA_W      (BA_W),
    .BURST_LEN (BURST_LEN),
    .T_RP      (T_RP),
    .T_WR      (T_WR)
  ) u_banks (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd_now),
    .bank_sel   (bank_sel),
    .bank_open  (bank_open),
    .bank_ready (bank_ready)
  );

  ddr_rule_check #(.BA_W(BA_W)) u_rules (
    .cmd        (cmd_now),
    .bank_sel   (bank_sel),
    .bank_open  (bank_open),
    .bank_ready (bank_ready),
    .viol       (viol_now),
    .cause      (cause_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_prev      <= 1'b0;
      cmd_code     <= CMD_IDLE;
      mode_ext     <= 1'b0;
      mode_operand <= '0;
      err_flag     <= 1'b0;
      err_cause    <= FLT_NONE;
    end else begin
      en_prev  <= clk_en;
      cmd_code <= cmd_now;
      mode_ext <= (cmd_now == CMD_MRS) && bank_sel[0];
      if (cmd_now == CMD_MRS) mode_operand <= {bank_sel, bus_addr};
      if (viol_now && !err_flag) begin
        err_flag  <= 1'b1;
        err_cause <= cause_now;
      end
    end
  end

endmodule

// File: rtl/ddr_mon_checker.sv
module ddr_mon_checker
  import ddr_mon_pkg::*;
#(
  parameter int unsigned BA_W = 2,
  localparam int unsigned NUM_BANKS = 1 << BA_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en_prev,
  input logic [3:0]           cmd_now,
  input logic                 viol_now,
  input logic [BA_W-1:0]      bank_sel,
  input logic [3:0]           cmd_code,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic                 err_flag,
  input logic [2:0]           err_cause
);

  assert_idle_without_cke_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_prev |=> cmd_code == 4'd12);

  assert_act_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_now == CMD_ACT |=> bank_open[$past(bank_sel)]);

  assert_prea_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_now == CMD_PREA |=> bank_open == '0);

  assert_act_open_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_now == CMD_ACT) && bank_open[bank_sel] |-> viol_now);

  assert_access_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    is_access(bus_cmd_e'(cmd_now)) && !bank_open[bank_sel] |-> viol_now);

  assert_mrs_open_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_now == CMD_MRS) && (|bank_open) |-> viol_now);

  assert_flag_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag && $stable(err_cause));

  assert_viol_sets_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
    viol_now |=> err_flag);

endmodule

bind ddr_cmd_monitor ddr_mon_checker #(.BA_W(BA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_prev   (en_prev),
  .cmd_now   (cmd_now),
  .viol_now  (viol_now),
  .bank_sel  (bank_sel),
  .cmd_code  (cmd_code),
  .bank_open (bank_open),
  .err_flag  (err_flag),
  .err_cause (err_cause)
);

// File: tb/tb_ddr_cmd_monitor.sv
module tb_ddr_cmd_monitor;

  localparam int BL = 4, TRP = 3, TWR = 2;
  localparam int RDG = BL / 2 + TRP;
  localparam int WRG = BL / 2 + 1 + TWR + TRP;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, clk_en = 1'b0, chip_sel_n = 1'b1;
  logic        row_strobe_n = 1'b1, col_strobe_n = 1'b1, wr_strobe_n = 1'b1;
  logic [1:0]  bank_sel = '0;
  logic [11:0] bus_addr = '0;
  logic [3:0]  cmd_code;
  logic        mode_ext;
  logic [13:0] mode_operand;
  logic [3:0]  bank_open;
  logic        err_flag;
  logic [2:0]  err_cause;

  ddr_cmd_monitor #(.ADDR_W(12), .AP_BIT(10), .BA_W(2), .BURST_LEN(BL),
                    .T_RP(TRP), .T_WR(TWR)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .chip_sel_n(chip_sel_n),
    .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n),
    .wr_strobe_n(wr_strobe_n), .bank_sel(bank_sel), .bus_addr(bus_addr),
    .cmd_code(cmd_code), .mode_ext(mode_ext), .mode_operand(mode_operand),
    .bank_open(bank_open), .err_flag(err_flag), .err_cause(err_cause));

  typedef struct packed {
    logic [3:0]  code;
    logic [3:0]  open;
    logic        flag;
    logic [2:0]  cause;
    logic        ext;
    logic [13:0] op;
  } obs_t;

  obs_t  exp_q[$];
  string tag_q[$];
  int    checks = 0, errors = 0;
  bit    done = 1'b0;

  // reference model: absolute cycle index per issued command
  bit        m_cke_prev;
  bit [3:0]  m_open;
  int        m_ready[4];
  int        cyc = 0;
  bit        m_flag, m_ext;
  bit [2:0]  m_cause;
  bit [13:0] m_op;

  function automatic bit [3:0] code_of(bit cp, bit cs, bit r, bit c, bit w, bit ap);
    if (!cp) return 4'd12;
    if (cs) return 4'd1;
    case ({r, c, w})
      3'b000: return 4'd2;
      3'b001: return 4'd3;
      3'b011: return 4'd4;
      3'b101: return ap ? 4'd6 : 4'd5;
      3'b100: return ap ? 4'd8 : 4'd7;
      3'b010: return ap ? 4'd10 : 4'd9;
      3'b110: return 4'd11;
      default: return 4'd0;
    endcase
  endfunction

  function automatic int later(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic model_reset();
    m_cke_prev = 0; m_open = '0; m_flag = 0; m_cause = 0; m_ext = 0; m_op = '0;
    for (int i = 0; i < 4; i++) m_ready[i] = 0;
  endtask

  task automatic issue(input bit e, input bit cs, input bit r, input bit c, input bit w,
                       input bit [1:0] b, input bit ap, input bit [11:0] a, input string tag);
    bit [3:0]  code;
    bit [2:0]  v;
    bit [11:0] aa;
    obs_t      o;
    @(negedge clk);
    aa = a; aa[10] = ap;
    clk_en = e; chip_sel_n = cs; row_strobe_n = r; col_strobe_n = c; wr_strobe_n = w;
    bank_sel = b; bus_addr = aa;
    code = code_of(m_cke_prev, cs, r, c, w, ap);
    v = 0;
    case (code)
      4'd4: begin
        if (m_open[b]) v = 1;
        else if (cyc < m_ready[b]) v = 2;
        m_open[b] = 1;
      end
      4'd5, 4'd7: if (!m_open[b]) v = 3;
      4'd6, 4'd8: begin
        if (!m_open[b]) v = 3;
        else begin
          m_open[b] = 0;
          m_ready[b] = later(m_ready[b], cyc + ((code == 4'd6) ? RDG : WRG));
        end
      end
      4'd9: begin
        m_open[b] = 0;
        m_ready[b] = later(m_ready[b], cyc + TRP);
      end
      4'd10: for (int i = 0; i < 4; i++) begin
        m_open[i] = 0;
        m_ready[i] = later(m_ready[i], cyc + TRP);
      end
      4'd2: begin
        if (m_open != 0) v = 4;
        else for (int i = 0; i < 4; i++) if (cyc < m_ready[i]) v = 5;
        m_op = {b, aa};
      end
      default: ;
    endcase
    m_ext = (code == 4'd2) && b[0];
    if (v != 0 && !m_flag) begin m_flag = 1; m_cause = v; end
    m_cke_prev = e;
    cyc++;
    o = '{code: code, open: m_open, flag: m_flag, cause: m_cause, ext: m_ext, op: m_op};
    exp_q.push_back(o);
    tag_q.push_back(tag);
  endtask

  task automatic nop(input string t);                issue(1,0,1,1,1,2'd0,0,12'h0,t); endtask
  task automatic act(input bit [1:0] b, input string t); issue(1,0,0,1,1,b,0,12'h123,t); endtask
  task automatic rd(input bit [1:0] b, input bit ap, input string t); issue(1,0,1,0,1,b,ap,12'h040,t); endtask
  task automatic wr(input bit [1:0] b, input bit ap, input string t); issue(1,0,1,0,0,b,ap,12'h080,t); endtask
  task automatic pre(input bit [1:0] b, input bit ap, input string t); issue(1,0,0,1,0,b,ap,12'h0,t); endtask
  task automatic mrs(input bit [1:0] b, input bit [11:0] a, input string t); issue(1,0,0,0,0,b,a[10],a,t); endtask
  task automatic idle_n(input int n, input string t);
    for (int i = 0; i < n; i++) nop(t);
  endtask

  task automatic do_reset();
    obs_t got;
    @(negedge clk);
    rst_n = 0; clk_en = 0; chip_sel_n = 1;
    model_reset();
    repeat (2) @(negedge clk);
    got = {cmd_code, bank_open, err_flag, err_cause, mode_ext, mode_operand};
    checks++;
    if (got !== obs_t'({4'd12, 4'd0, 1'b0, 3'd0, 1'b0, 14'd0})) begin
      errors++;
      $display("FAIL R13 reset state: got %h expected %h", got,
               obs_t'({4'd12, 4'd0, 1'b0, 3'd0, 1'b0, 14'd0}));
    end
    rst_n = 1;
    nop("R3 first cycle after reset decodes idle");
  endtask

  // monitor: one expectation per issued cycle, sampled after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        obs_t  e, g;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        g = {cmd_code, bank_open, err_flag, err_cause, mode_ext, mode_operand};
        checks++;
        if (g !== e) begin
          errors++;
          $display("FAIL %s: got code=%0d open=%b flag=%b cause=%0d ext=%b op=%h expected code=%0d open=%b flag=%b cause=%0d ext=%b op=%h",
                   t, g.code, g.open, g.flag, g.cause, g.ext, g.op,
                   e.code, e.open, e.flag, e.cause, e.ext, e.op);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();

    // R1 R2 R4 R5 decode sweep on an open bank
    act(2'd0, "R5 activate opens bank 0");
    rd(2'd0, 0, "R1 read decode");
    wr(2'd0, 0, "R1 write decode");
    issue(1,0,1,1,0,2'd0,0,12'h0, "R1 burst stop decode");
    issue(1,0,0,0,1,2'd3,0,12'h0, "R1 refresh decode");
    issue(1,1,0,0,0,2'd1,0,12'h0, "R2 deselect with strobes low");
    issue(1,1,1,0,1,2'd1,1,12'h0, "R2 deselect with read strobes");
    nop("R1 no operation decode");
    rd(2'd0, 1, "R4 read with auto-precharge");
    idle_n(RDG, "R9 wait out window");

    // R6 selective vs all precharge
    act(2'd0, "R5 open bank 0");
    act(2'd1, "R5 open bank 1");
    act(2'd2, "R5 open bank 2");
    pre(2'd1, 0, "R6 precharge bank 1 only");
    pre(2'd1, 1, "R6 precharge-all ignores bank select");

    // R3 clock enable low in previous cycle
    do_reset();
    issue(0,0,0,1,1,2'd1,0,12'h0, "R3 activate decoded while pin drops");
    act(2'd2, "R3 idle after enable low, bank 2 stays closed");
    act(2'd2, "R3 decoding resumes");

    // R8 explicit precharge window: too early
    do_reset();
    act(2'd1, "R8 open");
    pre(2'd1, 0, "R8 precharge");
    idle_n(TRP - 2, "R8 gap");
    act(2'd1, "R8 activate one cycle early flags cause 2");
    // R8 exactly at boundary
    do_reset();
    act(2'd1, "R8 open");
    pre(2'd1, 0, "R8 precharge");
    idle_n(TRP - 1, "R8 gap");
    act(2'd1, "R8 activate at tRP is legal");

    // R9 read auto-precharge window
    do_reset();
    act(2'd3, "R9 open");
    rd(2'd3, 1, "R9 read auto-precharge closes bank");
    idle_n(RDG - 2, "R9 gap");
    act(2'd3, "R9 early activate flags cause 2");
    do_reset();
    act(2'd3, "R9 open");
    rd(2'd3, 1, "R9 read auto-precharge");
    idle_n(RDG - 1, "R9 gap");
    act(2'd3, "R9 activate at boundary legal");

    // R10 write auto-precharge window
    do_reset();
    act(2'd2, "R10 open");
    wr(2'd2, 1, "R10 write auto-precharge closes bank");
    idle_n(WRG - 2, "R10 gap");
    act(2'd2, "R10 early activate flags cause 2");
    do_reset();
    act(2'd2, "R10 open");
    wr(2'd2, 1, "R10 write auto-precharge");
    idle_n(RDG - 1, "R10 gap past read window");
    act(2'd2, "R10 read-window boundary still early");
    do_reset();
    act(2'd2, "R10 open");
    wr(2'd2, 1, "R10 write auto-precharge");
    idle_n(WRG - 1, "R10 gap");
    act(2'd2, "R10 activate at boundary legal");

    // R7 and R13 stickiness
    do_reset();
    act(2'd2, "R7 open");
    act(2'd2, "R7 activate open bank flags cause 1");
    rd(2'd1, 0, "R13 later cause does not replace first");

    // R11 access to closed bank
    do_reset();
    act(2'd0, "R11 open bank 0");
    rd(2'd1, 1, "R11 auto-precharge read of closed bank flags cause 3");
    wr(2'd1, 0, "R11 bank state unchanged");

    // R12 mode register set rules
    do_reset();
    act(2'd0, "R12 open");
    mrs(2'd0, 12'h031, "R12 set with bank open flags cause 4");
    do_reset();
    act(2'd0, "R12 open");
    pre(2'd0, 1, "R12 precharge all");
    idle_n(TRP - 2, "R12 gap");
    mrs(2'd1, 12'h002, "R12 set before tRP flags cause 5");
    do_reset();
    act(2'd0, "R12 open");
    pre(2'd0, 1, "R12 precharge all");
    idle_n(TRP - 1, "R12 gap");
    mrs(2'd1, 12'h402, "R12 extended set legal, operand latched");
    mrs(2'd0, 12'h0A5, "R12 normal set, extended bit low");
    nop("R12 extended bit drops, operand held");

    wait (exp_q.size() == 0);
    @(posedge clk);
    #3;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule